// File: doc/BRIEF.md
# Sandcastle clamp and blanking generator

This block produces the line-rate part of a three-level sandcastle code as a 2-bit digital level. The output carries a clamp level during a fixed-width window placed at a programmable distance after each line start. It carries a blanking level from a point ahead of the flyback centre until the flyback trailing edge. A following analog stage turns the code into voltages.

Blanking has to begin before the flyback centre is seen. The block therefore counts clocks from each line start and records the offset at which the centre strobe arrived. On the next line it raises blanking a lead distance earlier than that offset. The lead follows the clocks-per-line value and stays within 38 to 41 clocks. A suppress bit removes the clamp window whenever the chip is in any mode other than normal.

All timing below counts rising clock edges. Edge 0 is the edge that samples `line_start_i` high. "Offset n" means the output value held after edge n and before edge n+1.

Top module: `sandcastle_hgen`

## Requirements
- R1: Each clamp window lasts exactly 21 consecutive clocks.
- R2: The clamp window begins at offset 35 + 2·S, where S is the unsigned value of `clamp_shift_i` (0..7). No clamp level appears before the first line start after reset.
- R3: Let C be the offset at which `fb_centre_i` was sampled on the previous line. Blanking begins at offset C − L, where L = K − 391 saturated to the range 38..41 and K is `clk_per_line_i`. When no centre offset has been recorded since reset, blanking begins at the offset where `fb_centre_i` is sampled.
- R4: Blanking is removed at the offset where `fb_trail_i` is sampled.
- R5: `mode_i` uses 00 for normal, 01 for wait, 10 for stop and 11 for protection. With `clamp_sup_i` = 1 and a mode other than normal, no clamp level is output. In normal mode, or with `clamp_sup_i` = 0, the bit has no effect.
- R6: `level_o` is 00 for base, 01 for blanking and 10 for clamp, and never 11. Where clamp and blanking overlap, the output is clamp.
- R7: While `rst_n` is low, `level_o` is 00. Reset also discards any recorded centre offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start_i | input | 1 | One-clock strobe at the qualified line start |
| fb_centre_i | input | 1 | One-clock strobe at the flyback centre |
| fb_trail_i | input | 1 | One-clock strobe at the flyback trailing edge |
| clamp_shift_i | input | 3 | Clamp delay setting |
| clk_per_line_i | input | 11 | Clocks per line, K |
| clamp_sup_i | input | 1 | Clamp suppress outside normal mode |
| mode_i | input | 2 | Operating mode |
| level_o | output | 2 | Sandcastle level code |

## Verification
The embedded properties check, on every cycle, the following: a clamp run never exceeds 21 clocks; no clamp follows a line start directly; suppression removes the clamp level on the next cycle; a trailing-edge strobe clears blanking; a centre strobe leaves the output above base; and the code 11 never appears. The exact clamp start for every shift value, the lead derived from K (including saturation at both ends) and the prediction from the previous line's centre offset can only be shown by the bench. It compares whole lines against an independent per-clock model. The fallback to the centre strobe after reset, and the loss of the recorded offset on a mid-line reset, are also shown only by the bench.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_WAIT    = 2'b01,
        MODE_STOP    = 2'b10,
        MODE_PROTECT = 2'b11
    } sc_mode_e;

    typedef enum logic [1:0] {
        LVL_BASE  = 2'b00,
        LVL_BLANK = 2'b01,
        LVL_CLAMP = 2'b10
    } sc_level_e;

endpackage

// File: rtl/sc_line_timer.sv
module sc_line_timer #(
    parameter int CNT_W      = 11,
    parameter int SHIFT_W    = 3,
    parameter int CLAMP_BASE = 35,
    parameter int CLAMP_STEP = 2,
    parameter int CLAMP_LEN  = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start_i,
    input  logic [SHIFT_W-1:0] clamp_shift_i,
    output logic [CNT_W-1:0]   cnt_nxt_o,
    output logic               clamp_win_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] WIN_SPAN = CNT_W'(CLAMP_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t s_d, s_q;
    logic [CNT_W-1:0] win_first, win_last;

    always_comb begin
        s_d = s_q;
        if (line_start_i) begin
            s_d.cnt = '0;
        end else if (s_q.cnt != CNT_MAX) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        win_first   = CNT_W'(CLAMP_BASE) + CNT_W'(CLAMP_STEP) * CNT_W'(clamp_shift_i);
        win_last    = win_first + WIN_SPAN;
        cnt_nxt_o   = s_d.cnt;
        clamp_win_o = (s_d.cnt != CNT_MAX) && (s_d.cnt >= win_first) && (s_d.cnt <= win_last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt <= CNT_MAX;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/sc_lead_calc.sv
module sc_lead_calc #(
    parameter int K_W      = 11,
    parameter int CNT_W    = 11,
    parameter int NOM_K    = 432,
    parameter int LEAD_MAX = 41,
    parameter int LEAD_MIN = 38
) (
    input  logic [K_W-1:0]   k_i,
    output logic [CNT_W-1:0] lead_o
);
    localparam int K_OFFSET = NOM_K - LEAD_MAX;

    int k_int;
    int raw;
    int sat;

    always_comb begin
        k_int = int'(k_i);
        raw   = k_int - K_OFFSET;
        if (raw > LEAD_MAX) begin
            sat = LEAD_MAX;
        end else if (raw < LEAD_MIN) begin
            sat = LEAD_MIN;
        end else begin
            sat = raw;
        end
        lead_o = CNT_W'(sat);
    end

endmodule

// File: rtl/sc_blank_ctrl.sv
module sc_blank_ctrl #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    input  logic             fb_centre_i,
    input  logic             fb_trail_i,
    input  logic [CNT_W-1:0] lead_i,
    output logic             blank_nxt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] centre;
        logic             valid;
        logic             blank;
    } blk_st_t;

    blk_st_t s_d, s_q;
    logic    start_hit;

    always_comb begin
        s_d       = s_q;
        start_hit = s_q.valid && (s_q.centre >= lead_i) &&
                    (cnt_nxt_i == s_q.centre - lead_i);
        s_d.blank = (s_q.blank || start_hit || fb_centre_i) && !fb_trail_i;
        if (fb_centre_i && (cnt_nxt_i != CNT_MAX)) begin
            s_d.centre = cnt_nxt_i;
            s_d.valid  = 1'b1;
        end
        blank_nxt_o = s_d.blank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_TRAIL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        fb_trail_i |=> !s_q.blank); // R4

endmodule

// File: rtl/sandcastle_hgen.sv
module sandcastle_hgen #(
    parameter int CNT_W      = 11,
    parameter int K_W        = 11,
    parameter int SHIFT_W    = 3,
    parameter int CLAMP_BASE = 35,
    parameter int CLAMP_STEP = 2,
    parameter int CLAMP_LEN  = 21,
    parameter int NOM_K      = 432,
    parameter int LEAD_MAX   = 41,
    parameter int LEAD_MIN   = 38
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start_i,
    input  logic               fb_centre_i,
    input  logic               fb_trail_i,
    input  logic [SHIFT_W-1:0] clamp_shift_i,
    input  logic [K_W-1:0]     clk_per_line_i,
    input  logic               clamp_sup_i,
    input  logic [1:0]         mode_i,
    output logic [1:0]         level_o
);
    import sc_pkg::*;

    typedef struct packed {
        logic [1:0] level;
    } top_st_t;

    top_st_t          s_d, s_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] lead;
    logic             clamp_win;
    logic             blank_nxt;
    logic             suppress;

    sc_line_timer #(
        .CNT_W(CNT_W), .SHIFT_W(SHIFT_W), .CLAMP_BASE(CLAMP_BASE),
        .CLAMP_STEP(CLAMP_STEP), .CLAMP_LEN(CLAMP_LEN)
    ) timer_i (
        .clk(clk), .rst_n(rst_n), .line_start_i(line_start_i),
        .clamp_shift_i(clamp_shift_i), .cnt_nxt_o(cnt_nxt), .clamp_win_o(clamp_win)
    );

    sc_lead_calc #(
        .K_W(K_W), .CNT_W(CNT_W), .NOM_K(NOM_K),
        .LEAD_MAX(LEAD_MAX), .LEAD_MIN(LEAD_MIN)
    ) lead_i (
        .k_i(clk_per_line_i), .lead_o(lead)
    );

    sc_blank_ctrl #(.CNT_W(CNT_W)) blank_i (
        .clk(clk), .rst_n(rst_n), .cnt_nxt_i(cnt_nxt), .fb_centre_i(fb_centre_i),
        .fb_trail_i(fb_trail_i), .lead_i(lead), .blank_nxt_o(blank_nxt)
    );

    always_comb begin
        s_d      = s_q;
        suppress = clamp_sup_i && (sc_mode_e'(mode_i) != MODE_NORMAL);
        if (clamp_win && !suppress) begin
            s_d.level = LVL_CLAMP;
        end else if (blank_nxt) begin
            s_d.level = LVL_BLANK;
        end else begin
            s_d.level = LVL_BASE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.level <= LVL_BASE;
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o = s_q.level;

    // Consecutive-clamp counter, used only by the length property below
    logic [7:0] clamp_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clamp_run_q <= '0;
        end else if (level_o == LVL_CLAMP) begin
            if (clamp_run_q != 8'hFF) clamp_run_q <= clamp_run_q + 1'b1;
        end else begin
            clamp_run_q <= '0;
        end
    end

    AST_CLAMP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_run_q <= 8'(CLAMP_LEN)); // R1
    AST_NO_CLAMP_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_i |=> level_o != LVL_CLAMP); // R2
    AST_CENTRE_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_centre_i && !fb_trail_i) |=> level_o != LVL_BASE); // R3
    AST_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_sup_i && mode_i != 2'b00) |=> level_o != LVL_CLAMP); // R5
    AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        level_o != 2'b11); // R6

endmodule

// File: tb/sandcastle_hgen_tb.sv
module sandcastle_hgen_tb_top;

    localparam int LINE  = 160;
    localparam int N_VEC = 12;
    // shift, K, centre offset, trail offset, suppress, mode
    localparam int V_S    [N_VEC] = '{0,   7,   3,   5,   2,   1,   4,   4,   6,   4,   0,   0};
    localparam int V_K    [N_VEC] = '{432, 432, 430, 429, 400, 500, 432, 432, 432, 432, 431, 432};
    localparam int V_C    [N_VEC] = '{100, 100, 90,  110, 100, 100, 100, 100, 100, 100, 60,  50};
    localparam int V_T    [N_VEC] = '{130, 130, 120, 140, 130, 130, 130, 130, 130, 130, 75,  60};
    localparam int V_SUP  [N_VEC] = '{0,   0,   0,   0,   0,   0,   1,   1,   1,   0,   0,   0};
    localparam int V_MODE [N_VEC] = '{0,   0,   0,   0,   0,   0,   1,   3,   0,   2,   0,   0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_start = 1'b0;
    logic       fb_centre = 1'b0;
    logic       fb_trail = 1'b0;
    logic [2:0] shift = '0;
    logic [10:0] kval = 11'd432;
    logic       sup = 1'b0;
    logic [1:0] mode = '0;
    logic [1:0] level;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    sandcastle_hgen dut_i (
        .clk(clk), .rst_n(rst_n), .line_start_i(line_start), .fb_centre_i(fb_centre),
        .fb_trail_i(fb_trail), .clamp_shift_i(shift), .clk_per_line_i(kval),
        .clamp_sup_i(sup), .mode_i(mode), .level_o(level)
    );

    function automatic int lead_of(input int k);
        int r;
        r = 41 - (432 - k);
        if (r > 41) r = 41;
        if (r < 38) r = 38;
        return r;
    endfunction

    function automatic logic [1:0] exp_level(input int n, input int s, input int k, input int c,
                                             input int t, input int sp, input int md, input int first);
        int  d, bs;
        logic cl, bl;
        d  = 35 + 2 * s;
        bs = (first != 0) ? c : c - lead_of(k);
        cl = !(sp != 0 && md != 0) && n >= d && n <= d + 20;
        bl = n >= bs && n < t;
        return cl ? 2'b10 : (bl ? 2'b01 : 2'b00);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // One line; when chk is set, every offset is compared and one check is counted
    task automatic run_line(input int c, input int t, input int chk, input int first, input string req);
        int  bad_n;
        logic [1:0] bad_a, bad_e;
        bad_n = -1;
        bad_a = '0;
        bad_e = '0;
        for (int i = 0; i < LINE; i++) begin
            @(negedge clk);
            line_start = (i == 0);
            fb_centre  = (i == c);
            fb_trail   = (i == t);
            @(posedge clk);
            #1;
            if (chk != 0 && bad_n < 0) begin
                logic [1:0] e;
                e = exp_level(i, int'(shift), int'(kval), c, t, int'(sup), int'(mode), first);
                if (level !== e) begin
                    bad_n = i;
                    bad_a = level;
                    bad_e = e;
                end
            end
        end
        @(negedge clk);
        line_start = 1'b0;
        fb_centre  = 1'b0;
        fb_trail   = 1'b0;
        if (chk != 0) begin
            if (bad_n >= 0) $display("FAIL detail %s at offset %0d", req, bad_n);
            check(bad_n < 0, req, int'(bad_a), int'(bad_e));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R7: reset state
        repeat (3) @(posedge clk);
        #1;
        check(level == 2'b00, "R7 reset level", int'(level), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: no clamp before first line start
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 80; i++) begin
                @(posedge clk);
                #1;
                if (level != 2'b00) seen++;
            end
            check(seen == 0, "R2 idle before line start", seen, 0);
        end

        // R3: first line after reset blanks from the centre strobe itself
        shift = 3'd0; kval = 11'd432; sup = 1'b0; mode = 2'b00;
        run_line(100, 130, 1, 1, "R3 first line fallback");
        run_line(100, 130, 1, 0, "R3 predicted start");

        // Table of vectors: R1 R2 R3 R4 R5 R6
        for (int v = 0; v < N_VEC; v++) begin
            @(negedge clk);
            shift = 3'(V_S[v]);
            kval  = 11'(V_K[v]);
            sup   = V_SUP[v] != 0;
            mode  = 2'(V_MODE[v]);
            run_line(V_C[v], V_T[v], 0, 0, "");
            run_line(V_C[v], V_T[v], 0, 0, "");
            run_line(V_C[v], V_T[v], 1, 0, $sformatf("R1 R2 R3 R4 R5 R6 vector %0d", v));
        end

        // R7: mid-line reset forces base and discards the stored centre
        @(negedge clk);
        shift = 3'd0; kval = 11'd432; sup = 1'b0; mode = 2'b00;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(level == 2'b00, "R7 mid-line reset", int'(level), 0);
        @(negedge clk);
        rst_n = 1'b1;
        run_line(100, 130, 1, 1, "R7 centre discarded by reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule